// File: doc/BRIEF.md
# I2C Multi-Bus Interrupt Status Aggregator

This block holds the interrupt state of every bus in a multi-bus I2C controller. Each bus has a 15-bit event status register and a 15-bit enable register. A command engine reports bus events as one-cycle pulses, and those pulses set status bits. Software reads and writes both registers through a simple register port. A status bit is cleared by writing a 1 to it.

When events arrive, the status is merged with the pulses and then ANDed with the enable register. Disabled events are therefore removed from the status, not only hidden from the interrupt. Each bus keeps a two-state interrupt machine, `IRQ_QUIET` or `IRQ_RAISED`:

- **`IRQ_QUIET` to `IRQ_RAISED`** happens when an evaluation leaves the masked status nonzero.
- **`IRQ_RAISED` to `IRQ_QUIET`** happens when a software status write leaves the status at zero.
- **All other cases** keep the current state.

The raised buses form a read-only global status word, one bit per bus indexed by bus id, and a single interrupt line that is the OR of that word.

A receive command can still be pending in the engine when software clears the receive-done bit. In that case the block sends a one-cycle fetch request to the engine so that it reads the next byte, and it evaluates the interrupt again.

Register port: `reg_addr` is `{bus index, select[1:0]}`. The select codes are:

| Select | Register |
|---|---|
| 0 | enable |
| 1 | status |
| 2 | global status word (the bus index is ignored) |
| 3 | reads zero |

Reads are combinational. Writes take effect at the clock edge.

Top module: `i2c_irq_aggregator`

## Requirements
- R1: An event pulse on an enabled bit sets that status bit at the next clock edge. The bit positions are:

  | Bit | Event |
  |---|---|
  | 0 | transmit acknowledged |
  | 1 | transmit not acknowledged |
  | 2 | receive done |
  | 3 | arbitration lost |
  | 4 | normal stop |
  | 5 | abnormal stop |
  | 6 | clock-line timeout |
  | 13 | recovery done |
  | 14 | data-line timeout |
- R2: The enable register keeps only bits 14:0 of a write (select 0). Bits 31:15 read back as zero.
- R3: Writing status (select 1) clears every bit written as 1. A bit written as 0 is unchanged.
- R4: On an evaluation, status bits whose enable bit is 0 are dropped from the status register.
- R5: If an evaluation leaves the masked status nonzero, the bus's bit in the global word (bit index = bus id) and `bus_irq` rise one cycle later, and `irq` is high.
- R6: A status write that leaves the bus status at zero clears the bus's global bit and `bus_irq` at the next edge.
- R7: A status write that clears bit 2 while bit 2 is set and `rx_cmd_pending` of that bus is high produces a one-cycle `rx_fetch` pulse after the write edge, and the interrupt is evaluated again. Without the pending flag there is no pulse.
- R8: Writes to the global word (select 2) have no effect.
- R9: Status bits 31:15, including the address-match bits 31:30, read as zero and cannot be changed by a write.
- R10: Reset clears enable, status, the global word, `bus_irq`, `irq` and `rx_fetch`.
- R11: When a software clear and an event pulse hit the same status bit in the same cycle, the clear wins.
- R12: `irq` is high exactly when at least one bus is raised, and buses raise independently of one another.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | `{bus index, select}` |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` |
| evt_pulse | input | NUM_BUSES*15 | Event pulses; bus b uses bits [b*15 +: 15] |
| rx_cmd_pending | input | NUM_BUSES | A receive or receive-last command is pending, per bus |
| rx_fetch | output | NUM_BUSES | One-cycle request to fetch the next byte |
| bus_irq | output | NUM_BUSES | Per-bus raised state |
| global_status | output | NUM_BUSES | Global per-bus status word |
| irq | output | 1 | Combined interrupt line |

## Verification
Two kinds of internal fault can hide inside a bus.

- **Wrong interrupt state.** A bus may sit in the wrong state, for example raised while its status is zero. This shows on `bus_irq`, `global_status` and `irq` in the same cycle. It is caught when the bench reads the global word back.
- **Wrong status contents.** A mask that is not applied, or a clear that loses to a same-cycle event, leaves a stray status bit. That bit can be read back one cycle after the event. It also shows up one write later, because a clearing write then fails to lower the bus interrupt.

A missed or spurious fetch request shows on `rx_fetch` in the cycle right after the status write.

// File: rtl/i2c_irq_pkg.sv
package i2c_irq_pkg;
    localparam int EVT_W = 15;
    localparam int DATA_W = 32;

    // Status bit positions (decoded by the command engine side).
    localparam int BIT_TX_ACK    = 0;
    localparam int BIT_TX_NAK    = 1;
    localparam int BIT_RX_DONE   = 2;
    localparam int BIT_ARB_LOST  = 3;
    localparam int BIT_STOP_OK   = 4;
    localparam int BIT_STOP_BAD  = 5;
    localparam int BIT_CLK_TMO   = 6;
    localparam int BIT_RECOVERED = 13;
    localparam int BIT_DATA_TMO  = 14;

    typedef enum logic [1:0] {
        SEL_ENABLE = 2'd0,
        SEL_STATUS = 2'd1,
        SEL_GLOBAL = 2'd2,
        SEL_NONE   = 2'd3
    } reg_sel_e;

    typedef enum logic {
        IRQ_QUIET  = 1'b0,
        IRQ_RAISED = 1'b1
    } irq_state_e;

    typedef struct packed {
        logic             wr_enable;
        logic             wr_status;
        logic [EVT_W-1:0] wdata;
    } slice_wr_t;
endpackage

// File: rtl/i2c_irq_decoder.sv
module i2c_irq_decoder
    import i2c_irq_pkg::*;
#(
    parameter int NUM_BUSES = 4,
    parameter int ADDR_W    = 4
) (
    input  logic                      reg_wr,
    input  logic [ADDR_W-1:0]         reg_addr,
    input  logic [EVT_W-1:0]          wdata_lo,
    output slice_wr_t [NUM_BUSES-1:0] slice_wr
);
    localparam int IDX_W = ADDR_W - 2;

    reg_sel_e sel;
    assign sel = reg_sel_e'(reg_addr[1:0]);

    for (genvar b = 0; b < NUM_BUSES; b++) begin : g_dec
        localparam logic [IDX_W-1:0] IDX = IDX_W'(b);
        logic hit;
        assign hit = reg_wr && (reg_addr[ADDR_W-1:2] == IDX);
        always_comb begin
            slice_wr[b].wr_enable = hit && (sel == SEL_ENABLE);
            slice_wr[b].wr_status = hit && (sel == SEL_STATUS);
            slice_wr[b].wdata     = wdata_lo;
        end
    end
endmodule

// File: rtl/i2c_irq_bus_slice.sv
module i2c_irq_bus_slice
    import i2c_irq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  slice_wr_t        wr_i,
    input  logic [EVT_W-1:0] evt_i,
    input  logic             rx_pend_i,
    output logic [EVT_W-1:0] enable_o,
    output logic [EVT_W-1:0] status_o,
    output logic             rx_fetch_o,
    output logic             irq_o
);
    logic [EVT_W-1:0] enable_q, status_q, status_d;
    logic [EVT_W-1:0] clr_mask, merged, masked;
    logic             raise, rearm, rx_fetch_q;
    irq_state_e       state_q, state_d;

    // Event/clear datapath
    always_comb begin
        clr_mask = wr_i.wr_status ? wr_i.wdata : '0;
        raise    = |evt_i;
        rearm    = wr_i.wr_status && status_q[BIT_RX_DONE] &&
                   wr_i.wdata[BIT_RX_DONE] && rx_pend_i;
        merged   = status_q | evt_i;
        masked   = (raise || rearm) ? (merged & enable_q) : merged;
        status_d = masked & ~clr_mask;   // clear applied last: wins over set
    end

    // Next-state logic of the interrupt machine
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            IRQ_QUIET:
                if ((raise || rearm) && (status_d != '0)) state_d = IRQ_RAISED;
            IRQ_RAISED:
                if (wr_i.wr_status && (status_d == '0)) state_d = IRQ_QUIET;
            default: state_d = IRQ_QUIET;
        endcase
    end

    // State and data registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= IRQ_QUIET;
            enable_q   <= '0;
            status_q   <= '0;
            rx_fetch_q <= 1'b0;
        end else begin
            state_q    <= state_d;
            status_q   <= status_d;
            rx_fetch_q <= rearm;
            if (wr_i.wr_enable) enable_q <= wr_i.wdata;
        end
    end

    // Outputs
    always_comb begin
        irq_o      = (state_q == IRQ_RAISED);
        enable_o   = enable_q;
        status_o   = status_q;
        rx_fetch_o = rx_fetch_q;
    end
endmodule

// File: rtl/i2c_irq_rdmux.sv
module i2c_irq_rdmux
    import i2c_irq_pkg::*;
#(
    parameter int NUM_BUSES = 4,
    parameter int ADDR_W    = 4
) (
    input  logic [ADDR_W-1:0]                 reg_addr,
    input  logic [NUM_BUSES-1:0][EVT_W-1:0]   enable_all,
    input  logic [NUM_BUSES-1:0][EVT_W-1:0]   status_all,
    input  logic [NUM_BUSES-1:0]              global_word,
    output logic [DATA_W-1:0]                 rdata
);
    localparam int IDX_W = ADDR_W - 2;

    logic [IDX_W-1:0] idx;
    logic             idx_ok;
    reg_sel_e         sel;

    assign idx    = reg_addr[ADDR_W-1:2];
    assign idx_ok = (int'(idx) < NUM_BUSES);
    assign sel    = reg_sel_e'(reg_addr[1:0]);

    always_comb begin
        rdata = '0;
        unique case (sel)
            SEL_ENABLE: if (idx_ok) rdata = DATA_W'(enable_all[idx]);
            SEL_STATUS: if (idx_ok) rdata = DATA_W'(status_all[idx]);
            SEL_GLOBAL: rdata = DATA_W'(global_word);
            SEL_NONE:   rdata = '0;
            default:    rdata = '0;
        endcase
    end
endmodule

// File: rtl/i2c_irq_aggregator.sv
module i2c_irq_aggregator
    import i2c_irq_pkg::*;
#(
    parameter int NUM_BUSES = 4,
    parameter int IDX_W     = (NUM_BUSES > 1) ? $clog2(NUM_BUSES) : 1,
    parameter int ADDR_W    = IDX_W + 2
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       reg_wr,
    input  logic [ADDR_W-1:0]          reg_addr,
    input  logic [31:0]                reg_wdata,
    output logic [31:0]                reg_rdata,
    input  logic [NUM_BUSES*15-1:0]    evt_pulse,
    input  logic [NUM_BUSES-1:0]       rx_cmd_pending,
    output logic [NUM_BUSES-1:0]       rx_fetch,
    output logic [NUM_BUSES-1:0]       bus_irq,
    output logic [NUM_BUSES-1:0]       global_status,
    output logic                       irq
);
    slice_wr_t [NUM_BUSES-1:0]         slice_wr;
    logic [NUM_BUSES-1:0][EVT_W-1:0]   enable_all;
    logic [NUM_BUSES-1:0][EVT_W-1:0]   status_all;
    logic                              unused_wdata_hi;

    assign unused_wdata_hi = ^reg_wdata[31:EVT_W];

    i2c_irq_decoder #(.NUM_BUSES(NUM_BUSES), .ADDR_W(ADDR_W)) u_dec (
        .reg_wr   (reg_wr),
        .reg_addr (reg_addr),
        .wdata_lo (reg_wdata[EVT_W-1:0]),
        .slice_wr (slice_wr)
    );

    for (genvar b = 0; b < NUM_BUSES; b++) begin : g_bus
        i2c_irq_bus_slice u_slice (
            .clk        (clk),
            .rst_n      (rst_n),
            .wr_i       (slice_wr[b]),
            .evt_i      (evt_pulse[b*EVT_W +: EVT_W]),
            .rx_pend_i  (rx_cmd_pending[b]),
            .enable_o   (enable_all[b]),
            .status_o   (status_all[b]),
            .rx_fetch_o (rx_fetch[b]),
            .irq_o      (bus_irq[b])
        );
    end

    assign global_status = bus_irq;
    assign irq           = |bus_irq;

    i2c_irq_rdmux #(.NUM_BUSES(NUM_BUSES), .ADDR_W(ADDR_W)) u_rd (
        .reg_addr    (reg_addr),
        .enable_all  (enable_all),
        .status_all  (status_all),
        .global_word (bus_irq),
        .rdata       (reg_rdata)
    );
endmodule

// File: rtl/i2c_irq_agg_checker.sv
module i2c_irq_agg_checker
    import i2c_irq_pkg::*;
#(
    parameter int NUM_BUSES = 4,
    parameter int ADDR_W    = 4
) (
    input logic                              clk,
    input logic                              rst_n,
    input logic                              reg_wr,
    input logic [ADDR_W-1:0]                 reg_addr,
    input logic [EVT_W-1:0]                  wdata_lo,
    input logic [NUM_BUSES*EVT_W-1:0]        evt_pulse,
    input logic [NUM_BUSES-1:0]              rx_cmd_pending,
    input logic [NUM_BUSES-1:0]              rx_fetch,
    input logic [NUM_BUSES-1:0]              bus_irq,
    input logic [NUM_BUSES-1:0][EVT_W-1:0]   enable_all,
    input logic [NUM_BUSES-1:0][EVT_W-1:0]   status_all
);
    localparam int IDX_W = ADDR_W - 2;

    for (genvar g = 0; g < NUM_BUSES; g++) begin : g_chk
        localparam logic [ADDR_W-1:0] STAT_ADDR = {IDX_W'(g), 2'd1};
        logic             wstat;
        logic [EVT_W-1:0] evt_g;
        assign wstat = reg_wr && (reg_addr == STAT_ADDR);
        assign evt_g = evt_pulse[g*EVT_W +: EVT_W];

        assert_w0_keeps_R3: assert property (@(posedge clk) disable iff (!rst_n)
            (wstat && wdata_lo == '0 && evt_g == '0) |=> $stable(status_all[g]));

        assert_mask_drops_R4: assert property (@(posedge clk) disable iff (!rst_n)
            (|evt_g) |=> ((status_all[g] & ~$past(enable_all[g])) == '0));

        assert_raise_R5: assert property (@(posedge clk) disable iff (!rst_n)
            ((|(evt_g & enable_all[g])) && !wstat) |=> bus_irq[g]);

        assert_clear_lowers_R6: assert property (@(posedge clk) disable iff (!rst_n)
            (wstat && (((status_all[g] | evt_g) & ~wdata_lo) == '0)) |=> !bus_irq[g]);

        assert_fetch_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
            rx_fetch[g] |-> $past(wstat && wdata_lo[BIT_RX_DONE] && rx_cmd_pending[g]));
    end
endmodule

bind i2c_irq_aggregator i2c_irq_agg_checker #(
    .NUM_BUSES(NUM_BUSES),
    .ADDR_W   (ADDR_W)
) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .reg_wr         (reg_wr),
    .reg_addr       (reg_addr),
    .wdata_lo       (reg_wdata[14:0]),
    .evt_pulse      (evt_pulse),
    .rx_cmd_pending (rx_cmd_pending),
    .rx_fetch       (rx_fetch),
    .bus_irq        (bus_irq),
    .enable_all     (enable_all),
    .status_all     (status_all)
);

// File: tb/i2c_irq_aggregator_tb.sv
module i2c_irq_aggregator_tb;
    localparam int NB = 4;
    localparam int AW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          reg_wr = 1'b0;
    logic [AW-1:0] reg_addr = '0;
    logic [31:0]   reg_wdata = '0;
    logic [31:0]   reg_rdata;
    logic [NB*15-1:0] evt_pulse = '0;
    logic [NB-1:0] rx_cmd_pending = '0;
    logic [NB-1:0] rx_fetch, bus_irq, global_status;
    logic          irq;

    int n_total = 0;
    int n_fail  = 0;
    bit done    = 0;

    always #2.5 clk = ~clk;

    i2c_irq_aggregator #(.NUM_BUSES(NB)) u_dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .evt_pulse(evt_pulse),
        .rx_cmd_pending(rx_cmd_pending), .rx_fetch(rx_fetch),
        .bus_irq(bus_irq), .global_status(global_status), .irq(irq)
    );

    function automatic logic [AW-1:0] ad(int bus, int sel);
        return {2'(bus), 2'(sel)};
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_total++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(logic [AW-1:0] a, logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(logic [AW-1:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic evt(int bus, logic [14:0] bits);
        @(negedge clk);
        evt_pulse[bus*15 +: 15] = bits;
        @(negedge clk);
        evt_pulse = '0;
    endtask

    task automatic wr_evt(int bus, logic [31:0] d, logic [14:0] bits);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = ad(bus, 1); reg_wdata = d;
        evt_pulse[bus*15 +: 15] = bits;
        @(negedge clk);
        reg_wr = 1'b0; evt_pulse = '0;
    endtask

    task automatic t_reset;
        logic [31:0] d;
        rd(ad(1, 0), d); check("R10 enable", d, 0);
        rd(ad(1, 1), d); check("R10 status", d, 0);
        check("R10 global", 32'(global_status), 0);
        check("R10 irq/fetch", {30'(0), irq, |rx_fetch}, 0);
    endtask

    task automatic t_enable_rw;
        logic [31:0] d;
        wr(ad(1, 0), 32'hFFFF_FFFF);
        rd(ad(1, 0), d); check("R2 enable width", d, 32'h7FFF);
    endtask

    task automatic t_event_raise;
        logic [31:0] d;
        evt(1, 15'h0001);
        rd(ad(1, 1), d); check("R1 tx ack bit0", d, 32'h1);
        check("R5 global bit1", 32'(global_status), 32'h2);
        check("R5 irq", 32'(irq), 1);
    endtask

    task automatic t_w1c;
        logic [31:0] d;
        wr(ad(1, 1), 32'h0);
        rd(ad(1, 1), d); check("R3 write0 keeps", d, 32'h1);
        check("R3 irq kept", 32'(bus_irq[1]), 1);
        wr(ad(1, 1), 32'hC000_0000);
        rd(ad(1, 1), d); check("R9 upper bits", d, 32'h1);
        wr(ad(1, 1), 32'h1);
        rd(ad(1, 1), d); check("R3 write1 clears", d, 0);
        check("R6 global low", 32'(global_status), 0);
        check("R6 irq low", 32'(irq), 0);
    endtask

    task automatic t_mask;
        logic [31:0] d;
        wr(ad(2, 0), 32'h0004);
        evt(2, 15'h0009);
        rd(ad(2, 1), d); check("R4 disabled dropped", d, 0);
        check("R4 no irq", 32'(bus_irq[2]), 0);
        evt(2, 15'h000C);
        rd(ad(2, 1), d); check("R4 only enabled kept", d, 32'h4);
        check("R5 bus2 raised", 32'(global_status), 32'h4);
        wr(ad(2, 1), 32'h4);
    endtask

    task automatic t_rearm;
        wr(ad(0, 0), 32'h7FFF);
        evt(0, 15'h0004);
        rx_cmd_pending[0] = 1'b1;
        wr(ad(0, 1), 32'h4);
        check("R7 fetch pulse", 32'(rx_fetch), 32'h1);
        check("R7 irq low after clear", 32'(bus_irq[0]), 0);
        @(negedge clk);
        check("R7 single pulse", 32'(rx_fetch), 0);
        rx_cmd_pending[0] = 1'b0;
        evt(0, 15'h0004);
        wr(ad(0, 1), 32'h4);
        check("R7 no pulse w/o pending", 32'(rx_fetch), 0);
    endtask

    task automatic t_priority;
        logic [31:0] d;
        wr(ad(3, 0), 32'h7FFF);
        wr_evt(3, 32'h10, 15'h0010);
        rd(ad(3, 1), d); check("R11 clear wins", d, 0);
        check("R11 no irq", 32'(bus_irq[3]), 0);
        wr_evt(3, 32'h10, 15'h0020);
        rd(ad(3, 1), d); check("R11 other bit set", d, 32'h20);
        check("R11 irq raised", 32'(bus_irq[3]), 1);
    endtask

    task automatic t_global_ro;
        logic [31:0] d;
        evt(1, 15'h4000);
        wr(ad(0, 2), 32'h0);
        rd(ad(0, 2), d); check("R8 global write ignored", d, 32'hA);
        check("R12 irq OR", 32'(irq), 1);
        wr(ad(1, 1), 32'h4000);
        wr(ad(3, 1), 32'h20);
        check("R12 all quiet", {31'(global_status), irq}, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_enable_rw();
        t_event_raise();
        t_w1c();
        t_mask();
        t_rearm();
        t_priority();
        t_global_ro();
        done = 1;
        $display("%0d/%0d checks passed", n_total - n_fail, n_total);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_total++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_total - n_fail, n_total);
            $finish;
        end
    end
endmodule